// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

The block measures the rate of one clock, picked from a vector of candidate monitored clocks, against one of two reference clocks. After software arms it, a window opens that lasts a programmable number of reference-clock ticks. The block counts edges of the selected monitored clock while the window is open, optionally after dividing that clock by a power of two. When the window closes, the count freezes and a done flag is raised. Software converts the count to a frequency by multiplying by the reference frequency and dividing by the window length.

Three clock domains take part. The register bus runs on `clk_i`. The window timer runs on the selected reference clock, and the edge counter runs on the selected monitored clock. The window gate crosses from the reference domain into the monitored domain through a two-flop synchronizer. The counter's completion flag crosses back into the bus domain the same way. The frozen count is captured only on the rising edge of that synchronized flag, so a read can never return a partial value.

A typical use is: pulse the soft-reset bit, write the configuration with enable set, wait at least one window, then read the data register. Each measurement starts from a soft reset.

Top module: `freq_meter`

## Requirements
- R1: The control register at byte address 0x10 reads back the fields written to it. These are bits 11:0 (window ticks minus one), bit 14 (soft reset), bit 15 (enable), bits 22:16 (monitored source index), bit 24 (reference select) and bits 29:28 (divider exponent). Every other bit reads 0, so writing 0xFFFFFFFF reads back 0x317FCFFF.
- R2: With enable set, the window lasts exactly (bits 11:0 + 1) ticks of the selected reference clock. The final count equals the number of selected monitored-clock edges in that time, within ±2.
- R3: Bits 22:16 select which entry of `mon_clks_i` is counted. An index at or above the number of inputs selects a constant-low clock.
- R4: Bit 24 = 0 times the window with `ref_clks_i[0]`, and bit 24 = 1 times it with `ref_clks_i[1]`.
- R5: A divider exponent n in bits 29:28 makes the count equal the monitored edges divided by 2^n, within ±2.
- R6: The data register at byte address 0x14 returns the count in bits CNT_W-1:0 and the done flag in bit 31. Until the window has completed, the whole word reads 0.
- R7: Once done is set, the count and done flag hold unchanged until the next soft reset.
- R8: While soft reset (bit 14) is set, the count and done flag are cleared and no measurement runs, even if enable is also set.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.
- R10: After the hardware reset `rst_ni`, both registers read 0.
- R11: Reads of any other address return 0, and writes to any other address leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| bus_wr_i | input | 1 | Write strobe, sampled on `clk_i` |
| bus_rd_i | input | 1 | Read strobe; `bus_rdata_o` is valid one cycle later |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| mon_clks_i | input | NUM_MON | Candidate monitored clocks |
| ref_clks_i | input | 2 | Candidate reference clocks |

## Verification
A wrong window length or a wrong clock selection shows up only as a count outside tolerance, and only after one full window. The bench therefore checks every measurement against a count computed from the known clock periods. A broken capture or done path shows at the data register as a nonzero word before completion, or as a changing word between two reads after completion, within a couple of bus cycles. A counter that wraps instead of saturating shows as a small count where the maximum is expected, on a narrow second instance, at the end of its window.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int WIN_W   = 12;
  localparam int SEL_W   = 7;
  localparam int DIV_W   = 2;
  localparam int PRE_W   = 3;
  localparam int NUM_REF = 2;
  localparam logic [7:0] ADDR_CTRL = 8'h10;
  localparam logic [7:0] ADDR_DATA = 8'h14;
  localparam int DONE_BIT = 31;

  typedef struct packed {
    logic [DIV_W-1:0] div_exp;
    logic             ref_sel;
    logic [SEL_W-1:0] mon_sel;
    logic             enable;
    logic             srst;
    logic [WIN_W-1:0] win_m1;
  } ctrl_t;

  // Field placement on the bus word.
  function automatic ctrl_t ctrl_unpack(logic [31:0] w);
    ctrl_t c;
    c.win_m1  = w[11:0];
    c.srst    = w[14];
    c.enable  = w[15];
    c.mon_sel = w[22:16];
    c.ref_sel = w[24];
    c.div_exp = w[29:28];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[11:0]  = c.win_m1;
    w[14]    = c.srst;
    w[15]    = c.enable;
    w[22:16] = c.mon_sel;
    w[24]    = c.ref_sel;
    w[29:28] = c.div_exp;
    return w;
  endfunction

  // Prescaler mask for division by 2^n.
  function automatic logic [PRE_W-1:0] pre_mask(logic [DIV_W-1:0] n);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(n)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/fm_sync.sv
module fm_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/fm_window.sv
module fm_window
  import fm_pkg::*;
(
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             en_async_i,
  input  logic             srst_async_i,
  input  logic [WIN_W-1:0] win_m1_i,
  output logic             gate_o
);
  typedef enum logic [1:0] {W_IDLE, W_RUN, W_FIN} wstate_e;

  logic             en_r, clr_r;
  wstate_e          state_q;
  logic [WIN_W-1:0] tick_q;
  logic             gate_q;

  fm_sync u_en_sync  (.clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(en_async_i),   .q_o(en_r));
  fm_sync u_clr_sync (.clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(srst_async_i), .q_o(clr_r));

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      tick_q  <= '0;
      gate_q  <= 1'b0;
    end else if (clr_r) begin
      state_q <= W_IDLE;
      tick_q  <= '0;
      gate_q  <= 1'b0;
    end else begin
      case (state_q)
        W_IDLE: if (en_r) begin
          state_q <= W_RUN;
          tick_q  <= '0;
          gate_q  <= 1'b1;
        end
        W_RUN: if (tick_q == win_m1_i) begin
          state_q <= W_FIN;
          gate_q  <= 1'b0;
        end else begin
          tick_q <= tick_q + 1'b1;
        end
        default: state_q <= W_FIN;
      endcase
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter
  import fm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             mon_clk_i,
  input  logic             rst_ni,
  input  logic             gate_async_i,
  input  logic             srst_async_i,
  input  logic [DIV_W-1:0] div_exp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             gate_s, gate_d, clr_s, done_q;
  logic [PRE_W-1:0] pre_q, mask;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  fm_sync u_gate_sync (.clk_i(mon_clk_i), .rst_ni(rst_ni), .d_i(gate_async_i), .q_o(gate_s));
  fm_sync u_clr_sync  (.clk_i(mon_clk_i), .rst_ni(rst_ni), .d_i(srst_async_i), .q_o(clr_s));

  assign mask = pre_mask(div_exp_i);
  assign tick = gate_s && ((pre_q & mask) == mask);

  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_s) begin
      gate_d <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_s) pre_q <= pre_q + 1'b1;
      if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (gate_d && !gate_s) done_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
  assign clr_o  = clr_s;
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int NUM_MON = 8,
  parameter int CNT_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_MON-1:0] mon_clks_i,
  input  logic [NUM_REF-1:0] ref_clks_i
);
  localparam int MON_IDX_W = (NUM_MON > 1) ? $clog2(NUM_MON) : 1;

  ctrl_t            ctrl_q;
  logic             mon_clk, ref_clk;
  logic             gate_r;
  logic [CNT_W-1:0] mon_cnt;
  logic             mon_done, mon_clr;
  logic             done_s, done_s_d, done_rise;
  logic             done_bus;
  logic [CNT_W-1:0] cnt_bus;
  logic             srst_bus;
  logic [31:0]      rdata_q, data_word;

  assign srst_bus = ctrl_q.srst;

  // Clock selection.
  always_comb begin
    if (int'(ctrl_q.mon_sel) < NUM_MON) mon_clk = mon_clks_i[ctrl_q.mon_sel[MON_IDX_W-1:0]];
    else                                mon_clk = 1'b0;
  end
  assign ref_clk = ref_clks_i[ctrl_q.ref_sel];

  fm_window u_window (
    .ref_clk_i   (ref_clk),
    .rst_ni      (rst_ni),
    .en_async_i  (ctrl_q.enable),
    .srst_async_i(ctrl_q.srst),
    .win_m1_i    (ctrl_q.win_m1),
    .gate_o      (gate_r)
  );

  fm_edge_counter #(.CNT_W(CNT_W)) u_counter (
    .mon_clk_i   (mon_clk),
    .rst_ni      (rst_ni),
    .gate_async_i(gate_r),
    .srst_async_i(ctrl_q.srst),
    .div_exp_i   (ctrl_q.div_exp),
    .cnt_o       (mon_cnt),
    .done_o      (mon_done),
    .clr_o       (mon_clr)
  );

  fm_sync u_done_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(mon_done), .q_o(done_s));
  assign done_rise = done_s && !done_s_d;

  // Bus domain: control register and count capture.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      done_s_d <= 1'b0;
      done_bus <= 1'b0;
      cnt_bus  <= '0;
    end else begin
      if (bus_wr_i && bus_addr_i == ADDR_CTRL) ctrl_q <= ctrl_unpack(bus_wdata_i);
      done_s_d <= done_s;
      if (srst_bus) begin
        done_bus <= 1'b0;
        cnt_bus  <= '0;
      end else if (done_rise && !done_bus) begin
        done_bus <= 1'b1;
        cnt_bus  <= mon_cnt;
      end
    end
  end

  always_comb begin
    data_word                = '0;
    data_word[CNT_W-1:0]     = cnt_bus;
    data_word[DONE_BIT]      = done_bus;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (bus_rd_i) begin
      case (bus_addr_i)
        ADDR_CTRL: rdata_q <= ctrl_pack(ctrl_q);
        ADDR_DATA: rdata_q <= data_word;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/fm_checker.sv
module fm_checker
  import fm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_rd_i,
  input logic [7:0]       bus_addr_i,
  input logic [31:0]      bus_rdata_o,
  input logic             srst_bus,
  input logic             done_bus,
  input logic [CNT_W-1:0] cnt_bus,
  input logic             mon_clk,
  input logic             mon_clr,
  input logic             mon_done,
  input logic [CNT_W-1:0] mon_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r9_no_wrap: assert property (@(posedge mon_clk) disable iff (!rst_ni)
    (mon_cnt == CNT_MAX) |=> (mon_cnt == CNT_MAX) || $past(mon_clr));

  a_r2_count_stops_after_window: assert property (@(posedge mon_clk) disable iff (!rst_ni)
    mon_done |=> $stable(mon_cnt) || $past(mon_clr));

  a_r7_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_bus && !srst_bus) |=> done_bus && $stable(cnt_bus));

  a_r8_soft_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_bus |=> !done_bus && (cnt_bus == '0));

  a_r6_no_partial_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == ADDR_DATA && !done_bus) |=> (bus_rdata_o == 32'h0));
endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rd_i   (bus_rd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .srst_bus   (srst_bus),
  .done_bus   (done_bus),
  .cnt_bus    (cnt_bus),
  .mon_clk    (mon_clk),
  .mon_clr    (mon_clr),
  .mon_done   (mon_done),
  .mon_cnt    (mon_cnt)
);

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
  localparam int NMON = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_sat;
  logic [NMON-1:0] mon = '0;
  logic [1:0]  refc = '0;

  int n_checks = 0;
  int n_fail   = 0;

  // Clock half periods in ns.
  int mon_half [NMON] = '{5, 7, 11, 15, 23, 3, 9, 13};
  int ref_half [2]    = '{20, 50};

  always #10 clk = ~clk;
  for (genvar g = 0; g < NMON; g++) begin : g_mon
    always #(mon_half[g]) mon[g] = ~mon[g];
  end
  always #(ref_half[0]) refc[0] = ~refc[0];
  always #(ref_half[1]) refc[1] = ~refc[1];

  freq_meter #(.NUM_MON(NMON), .CNT_W(24)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mon_clks_i(mon), .ref_clks_i(refc));

  freq_meter #(.NUM_MON(NMON), .CNT_W(8)) sat_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_sat), .mon_clks_i(mon), .ref_clks_i(refc));

  function automatic logic [31:0] cfg(int sel, int rsel, int dexp, int win, bit en, bit sr);
    return (32'(dexp) << 28) | (32'(rsel) << 24) | (32'(sel) << 16) |
           (32'(en) << 15) | (32'(sr) << 14) | 32'(win - 1);
  endfunction

  // Ideal count: window time over divided monitored period.
  function automatic int ideal_count(int sel, int rsel, int dexp, int win);
    return (win * 2 * ref_half[rsel]) / ((2 * mon_half[sel]) << dexp);
  endfunction

  task automatic check(bit ok, string req, longint got, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata; ds = rdata_sat;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_reset();
    bus_write(8'h10, 32'h0000_4000);
    idle(20);
    bus_write(8'h10, 32'h0);
    idle(20);
  endtask

  // Start a measurement and poll until done; returns both data words.
  task automatic measure(int sel, int rsel, int dexp, int win,
                         output logic [31:0] d, output logic [31:0] ds);
    logic [31:0] x, xs;
    soft_reset();
    bus_write(8'h10, cfg(sel, rsel, dexp, win, 1'b1, 1'b0));
    x = '0; xs = '0;
    for (int i = 0; i < 6000 && !x[31]; i++) bus_read(8'h14, x, xs);
    d = x;
    idle(10);
    bus_read(8'h14, x, xs);
    ds = xs;
  endtask

  task automatic check_measure(string req, int sel, int rsel, int dexp, int win);
    logic [31:0] d, ds, d2, ds2;
    int exp_c, got;
    measure(sel, rsel, dexp, win, d, ds);
    exp_c = ideal_count(sel, rsel, dexp, win);
    got   = int'(d[23:0]);
    check(d[31] && (got >= exp_c - 2) && (got <= exp_c + 2), req, got, exp_c);
    bus_read(8'h14, d2, ds2);
    check(d2 == d, "R7 held after done", d2, d);
  endtask

  initial begin
    logic [31:0] d, ds;
    int sel, rsel, dexp, win;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    bus_read(8'h10, d, ds);
    check(d == 32'h0, "R10 ctrl reset", d, 0);
    bus_read(8'h14, d, ds);
    check(d == 32'h0, "R10 data reset", d, 0);

    // R1 field readback; R8 srst dominates enable.
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, d, ds);
    check(d == 32'h317F_CFFF, "R1 ctrl readback", d, 32'h317F_CFFF);
    idle(40);
    bus_read(8'h14, d, ds);
    check(d == 32'h0, "R8 no run under soft reset", d, 0);
    bus_write(8'h10, 32'h0);

    // R11 other addresses.
    bus_write(8'h20, 32'h0000_8123);
    bus_read(8'h10, d, ds);
    check(d == 32'h0, "R11 write elsewhere ignored", d, 0);
    bus_read(8'h18, d, ds);
    check(d == 32'h0, "R11 read elsewhere zero", d, 0);

    // R6 no partial value right after arming.
    soft_reset();
    bus_write(8'h10, cfg(0, 0, 0, 512, 1'b1, 1'b0));
    idle(30);
    bus_read(8'h14, d, ds);
    check(d == 32'h0, "R6 zero before done", d, 0);

    // Directed: 512-tick window, 10 ns monitored clock, 40 ns reference.
    measure(0, 0, 0, 512, d, ds);
    check(d[31] && d[23:0] >= 2046 && d[23:0] <= 2050, "R2 512-tick window", d[23:0], 2048);
    check(ds == 32'h8000_00FF, "R9 saturation on narrow counter", ds, 32'h8000_00FF);
    soft_reset();
    bus_read(8'h14, d, ds);
    check(d == 32'h0, "R8 soft reset clears result", d, 0);

    check_measure("R5 divide by 4", 0, 0, 2, 512);
    check_measure("R5 divide by 8", 3, 0, 3, 800);
    check_measure("R4 second reference", 0, 1, 0, 100);
    check_measure("R3 source index 4", 4, 0, 0, 300);
    check_measure("R3 source index 5", 5, 1, 0, 64);
    check_measure("R2 single-tick window", 5, 1, 0, 1);

    // R3 out-of-range source: no edges, no done within a window.
    soft_reset();
    bus_write(8'h10, cfg(100, 0, 0, 16, 1'b1, 1'b0));
    idle(200);
    bus_read(8'h14, d, ds);
    check(d == 32'h0, "R3 out-of-range source idle", d, 0);

    for (int k = 0; k < 8; k++) begin
      sel  = int'($urandom_range(NMON - 1, 0));
      rsel = int'($urandom_range(1, 0));
      dexp = int'($urandom_range(3, 0));
      win  = int'($urandom_range(300, 32));
      check_measure("R2 random measurement", sel, rsel, dexp, win);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule